// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block is the coherence engine that sits beside one private cache in a small shared-bus multiprocessor. It holds a direct-mapped array of lines, each with a tag, a data word and one of three coherence states. Invalid means the line holds nothing. Shared means the line is a clean, read-only copy. Exclusive means the line is the only copy, may be written, and is dirty with respect to memory. The processor issues one request at a time on the CPU port and holds it until `cpu_done_o` pulses. Requests that the local state can satisfy finish without the bus. Any other request arbitrates for the shared bus, and the line changes only in the cycle the grant is used.

In parallel the block watches the commands that other caches place on the bus. A read miss or write miss from another cache that matches a local valid line demotes that line. If the line was dirty, the block supplies its data in place of memory. If such a snoop hits the block that a waiting request targets, the snoop is serviced first. The waiting request then drops back to idle and is decided again against the new line state.

Two state machines drive the block. The request machine has four states. `CS_IDLE` accepts and decides requests. `CS_WB` waits for the grant that evicts a dirty victim. `CS_MISS` waits for the grant that carries the read or write miss. `CS_RESP` pulses done. Its transitions are: IDLE to RESP on a hit; IDLE to WB on a miss with a dirty victim; IDLE to MISS on any other miss; WB to MISS on grant; WB to IDLE and MISS to IDLE on a snoop that hits the pending block (restart); MISS to RESP on grant; RESP to IDLE. The per-line snoop machine moves lines from Exclusive to Shared on a remote read miss, from Exclusive to Invalid on a remote write miss, and from Shared to Invalid on a remote write miss.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_done_o`, `bus_req_o`, `snp_flush_o` are 0 with `bus_cmd_o` = 00 (no command).
- R2: A read whose line is Invalid or holds another clean tag raises `bus_req_o`. In the grant cycle it drives command 01 (read miss) with the request address. It stores `bus_rdata_i` with state Shared and returns that value with `cpu_done_o` in the next cycle.
- R3: A write to an Invalid line, or to a Shared line of the same tag (upgrade), is treated as a miss. In the grant cycle it drives command 10 (write miss) and leaves the line Exclusive, holding the written data.
- R4: A read that hits Shared or Exclusive, and a write that hits Exclusive, raise `cpu_done_o` one cycle after the request is accepted, with no bus request. A read returns the stored word.
- R5: A miss whose line is Exclusive under another tag first drives command 11 (write-back) with the victim address and data. The miss command follows in a later grant cycle.
- R6: A snooped write miss (10) to a Shared line makes it Invalid without a flush.
- R7: A snooped read miss (01) to an Exclusive line raises `snp_flush_o` in the next cycle with the dirty word on `snp_flush_data_o`. The line becomes Shared.
- R8: A snooped write miss to an Exclusive line flushes in the same way and leaves the line Invalid.
- R9: No line changes and no bus command is driven before grant. A snoop read or write miss to the block awaited in CS_WB or CS_MISS sends the machine back to idle, and the request is decided again.
- R10: A snoop command in the same cycle as an idle request delays acceptance by one cycle. Snoops with command 11, or with a non-matching tag, change nothing.
- R11: `cpu_done_o` is a single-cycle pulse, and `bus_req_o` stays high from miss detection until the grant cycle that completes the bus phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_i | input | 1 | Processor request, held until done |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address (index in low bits, tag above) |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read data, valid with done |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_cmd_o | output | 2 | Driven command: 00 none, 01 read miss, 10 write miss, 11 write-back |
| bus_addr_o | output | ADDR_W | Address of driven command |
| bus_data_o | output | DATA_W | Write-back data |
| bus_rdata_i | input | DATA_W | Fill data returned during a granted miss |
| snp_cmd_i | input | 2 | Command observed from another cache |
| snp_addr_i | input | ADDR_W | Address observed from another cache |
| snp_flush_o | output | 1 | Dirty data supplied for the previous snoop |
| snp_flush_data_o | output | DATA_W | Flushed word |

## Verification
A hit shows `cpu_done_o` in the first cycle after acceptance, or one cycle later when a snoop shares the acceptance cycle. A bus command is visible only while the grant is high, and done follows in the next cycle. A flush appears in the cycle after the snoop. Stimulus is applied just after a rising edge, and the grant a little later. Outputs are read at the falling edge, so each check falls inside the cycle in which its result is due. Latencies are counted in falling edges from the request. Expected bus commands, flushes and responses are queued in order, so a missing, extra or reordered event is reported.

// File: rtl/msi_pkg.sv
package msi_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'b00,
        BC_RDMISS = 2'b01,
        BC_WRMISS = 2'b10,
        BC_WRBACK = 2'b11
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_WB,
        CS_MISS,
        CS_RESP
    } cpu_st_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_state,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_state,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_e          wr_state,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int NLINES = 1 << IDX_W;

    line_st_e          st_q   [NLINES];
    logic [TAG_W-1:0]  tag_q  [NLINES];
    logic [DATA_W-1:0] data_q [NLINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLINES; i++) st_q[i] <= LN_INV;
        end else if (wr_en) begin
            st_q[wr_idx] <= wr_state;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            if (wr_data_en) data_q[wr_idx] <= wr_data;
        end
    end

    assign a_state = st_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = data_q[a_idx];
    assign b_state = st_q[b_idx];
    assign b_tag   = tag_q[b_idx];
    assign b_data  = data_q[b_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_cmd_e          snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_e          line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              snp_act,
    output logic              upd_en,
    output line_st_e          upd_state,
    output logic              flush_o,
    output logic [DATA_W-1:0] flush_data_o
);
    logic snp_hit;
    logic flush_n;

    assign snp_act = (snp_cmd == BC_RDMISS) || (snp_cmd == BC_WRMISS);
    assign snp_hit = snp_act && (line_state != LN_INV) && (line_tag == snp_tag);

    always_comb begin
        upd_en    = 1'b0;
        upd_state = line_state;
        flush_n   = 1'b0;
        if (snp_hit) begin
            unique case (line_state)
                LN_EXC: begin
                    flush_n   = 1'b1;
                    upd_en    = 1'b1;
                    upd_state = (snp_cmd == BC_RDMISS) ? LN_SHR : LN_INV;
                end
                LN_SHR: begin
                    if (snp_cmd == BC_WRMISS) begin
                        upd_en    = 1'b1;
                        upd_state = LN_INV;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_o      <= 1'b0;
            flush_data_o <= '0;
        end else begin
            flush_o      <= flush_n;
            flush_data_o <= flush_n ? line_data : '0;
        end
    end
endmodule

// File: rtl/msi_cpu_fsm.sv
module msi_cpu_fsm
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_done,
    output logic [DATA_W-1:0]       cpu_rdata,
    input  line_st_e                line_state,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  logic [DATA_W-1:0]       line_data,
    input  logic                    snp_act,
    input  logic [ADDR_W-1:0]       snp_addr,
    output logic                    bus_req,
    input  logic                    bus_gnt,
    output bus_cmd_e                bus_cmd,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [DATA_W-1:0]       bus_data,
    input  logic [DATA_W-1:0]       bus_rdata,
    output logic                    lw_en,
    output line_st_e                lw_state,
    output logic [ADDR_W-IDX_W-1:0] lw_tag,
    output logic                    lw_data_en,
    output logic [DATA_W-1:0]       lw_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    cpu_st_e           st_q, st_n;
    logic              rd_en;
    logic [DATA_W-1:0] rd_n;
    logic [TAG_W-1:0]  req_tag;
    logic [ADDR_W-1:0] victim_addr;
    logic              tag_eq, rd_hit, wr_hit, victim_dirty, pend_snp;

    assign req_tag      = cpu_addr[ADDR_W-1:IDX_W];
    assign tag_eq       = (line_tag == req_tag);
    assign victim_addr  = {line_tag, cpu_addr[IDX_W-1:0]};
    assign rd_hit       = (line_state != LN_INV) && tag_eq;
    assign wr_hit       = (line_state == LN_EXC) && tag_eq;
    assign victim_dirty = (line_state == LN_EXC) && !tag_eq;
    assign pend_snp     = snp_act &&
                          (snp_addr == ((st_q == CS_WB) ? victim_addr : cpu_addr));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= CS_IDLE;
            cpu_rdata <= '0;
        end else begin
            st_q <= st_n;
            if (rd_en) cpu_rdata <= rd_n;
        end
    end

    always_comb begin
        st_n       = st_q;
        bus_req    = 1'b0;
        bus_cmd    = BC_NONE;
        bus_addr   = '0;
        bus_data   = '0;
        lw_en      = 1'b0;
        lw_state   = line_state;
        lw_tag     = line_tag;
        lw_data_en = 1'b0;
        lw_data    = cpu_wdata;
        rd_en      = 1'b0;
        rd_n       = line_data;
        unique case (st_q)
            CS_IDLE: begin
                if (cpu_req && !snp_act) begin
                    if (cpu_we ? wr_hit : rd_hit) begin
                        st_n  = CS_RESP;
                        rd_en = 1'b1;
                        if (cpu_we) begin
                            rd_n       = cpu_wdata;
                            lw_en      = 1'b1;
                            lw_state   = LN_EXC;
                            lw_tag     = req_tag;
                            lw_data_en = 1'b1;
                        end
                    end else if (victim_dirty) begin
                        st_n = CS_WB;
                    end else begin
                        st_n = CS_MISS;
                    end
                end
            end
            CS_WB: begin
                bus_req = 1'b1;
                if (pend_snp) begin
                    st_n = CS_IDLE;
                end else if (bus_gnt && !snp_act) begin
                    bus_cmd  = BC_WRBACK;
                    bus_addr = victim_addr;
                    bus_data = line_data;
                    lw_en    = 1'b1;
                    lw_state = LN_INV;
                    st_n     = CS_MISS;
                end
            end
            CS_MISS: begin
                bus_req = 1'b1;
                if (pend_snp) begin
                    st_n = CS_IDLE;
                end else if (bus_gnt && !snp_act) begin
                    bus_cmd    = cpu_we ? BC_WRMISS : BC_RDMISS;
                    bus_addr   = cpu_addr;
                    lw_en      = 1'b1;
                    lw_state   = cpu_we ? LN_EXC : LN_SHR;
                    lw_tag     = req_tag;
                    lw_data_en = 1'b1;
                    lw_data    = cpu_we ? cpu_wdata : bus_rdata;
                    rd_en      = 1'b1;
                    rd_n       = cpu_we ? cpu_wdata : bus_rdata;
                    st_n       = CS_RESP;
                end
            end
            CS_RESP: begin
                st_n = CS_IDLE;
            end
        endcase
    end

    assign cpu_done = (st_q == CS_RESP);
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              cpu_done_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic [1:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic [1:0]        snp_cmd_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    output logic              snp_flush_o,
    output logic [DATA_W-1:0] snp_flush_data_o
);
    localparam int TAG_W = ADDR_W - IDX_W;

    line_st_e          a_state, b_state, cpu_lw_state, snp_upd_state, wr_state;
    logic [TAG_W-1:0]  a_tag, b_tag, cpu_lw_tag, wr_tag;
    logic [DATA_W-1:0] a_data, b_data, cpu_lw_data;
    logic              cpu_lw_en, cpu_lw_data_en, snp_upd_en, snp_act;
    logic              wr_en, wr_data_en;
    logic [IDX_W-1:0]  wr_idx;
    bus_cmd_e          bus_cmd;

    assign wr_en      = snp_upd_en | cpu_lw_en;
    assign wr_idx     = snp_upd_en ? snp_addr_i[IDX_W-1:0] : cpu_addr_i[IDX_W-1:0];
    assign wr_state   = snp_upd_en ? snp_upd_state : cpu_lw_state;
    assign wr_tag     = snp_upd_en ? b_tag : cpu_lw_tag;
    assign wr_data_en = !snp_upd_en && cpu_lw_data_en;
    assign bus_cmd_o  = bus_cmd;

    msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .a_idx      (cpu_addr_i[IDX_W-1:0]),
        .a_state    (a_state),
        .a_tag      (a_tag),
        .a_data     (a_data),
        .b_idx      (snp_addr_i[IDX_W-1:0]),
        .b_state    (b_state),
        .b_tag      (b_tag),
        .b_data     (b_data),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_state   (wr_state),
        .wr_tag     (wr_tag),
        .wr_data_en (wr_data_en),
        .wr_data    (cpu_lw_data)
    );

    msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) snoop_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .snp_cmd      (bus_cmd_e'(snp_cmd_i)),
        .snp_tag      (snp_addr_i[ADDR_W-1:IDX_W]),
        .line_state   (b_state),
        .line_tag     (b_tag),
        .line_data    (b_data),
        .snp_act      (snp_act),
        .upd_en       (snp_upd_en),
        .upd_state    (snp_upd_state),
        .flush_o      (snp_flush_o),
        .flush_data_o (snp_flush_data_o)
    );

    msi_cpu_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req_i),
        .cpu_we     (cpu_we_i),
        .cpu_addr   (cpu_addr_i),
        .cpu_wdata  (cpu_wdata_i),
        .cpu_done   (cpu_done_o),
        .cpu_rdata  (cpu_rdata_o),
        .line_state (a_state),
        .line_tag   (a_tag),
        .line_data  (a_data),
        .snp_act    (snp_act),
        .snp_addr   (snp_addr_i),
        .bus_req    (bus_req_o),
        .bus_gnt    (bus_gnt_i),
        .bus_cmd    (bus_cmd),
        .bus_addr   (bus_addr_o),
        .bus_data   (bus_data_o),
        .bus_rdata  (bus_rdata_i),
        .lw_en      (cpu_lw_en),
        .lw_state   (cpu_lw_state),
        .lw_tag     (cpu_lw_tag),
        .lw_data_en (cpu_lw_data_en),
        .lw_data    (cpu_lw_data)
    );
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_req_i,
    input logic       cpu_done_o,
    input logic       bus_req_o,
    input logic       bus_gnt_i,
    input logic [1:0] bus_cmd_o,
    input logic [1:0] snp_cmd_i,
    input logic       snp_flush_o
);
    p_cmd_needs_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o != 2'b00) |-> (bus_req_o && bus_gnt_i));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done_o |=> !cpu_done_o);

    p_req_dropped_at_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done_o |-> !bus_req_o);

    p_done_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done_o |-> $past(cpu_req_i));

    p_wb_then_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o == 2'b11) |=> bus_req_o);

    p_flush_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush_o |-> ($past(snp_cmd_i) == 2'b01 || $past(snp_cmd_i) == 2'b10));

    p_snoop_blocks_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_cmd_i != 2'b00) |-> (bus_cmd_o == 2'b00));
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk chk_i (.*);

// File: tb/msi_snoop_ctrl_tb_top.sv
module msi_snoop_ctrl_tb_top;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_req_i = 1'b0, cpu_we_i = 1'b0;
    logic [AW-1:0] cpu_addr_i = '0;
    logic [DW-1:0] cpu_wdata_i = '0;
    logic          cpu_done_o;
    logic [DW-1:0] cpu_rdata_o;
    logic          bus_req_o;
    logic          bus_gnt_i = 1'b0;
    logic [1:0]    bus_cmd_o;
    logic [AW-1:0] bus_addr_o;
    logic [DW-1:0] bus_data_o;
    logic [DW-1:0] bus_rdata_i;
    logic [1:0]    snp_cmd_i = 2'b00;
    logic [AW-1:0] snp_addr_i = '0;
    logic          snp_flush_o;
    logic [DW-1:0] snp_flush_data_o;

    int            n_chk = 0;
    int            n_bad = 0;
    logic [DW-1:0] mem [256];
    logic [AW-1:0] last_snp = '0;
    bit            gnt_en = 1'b1;

    logic [1:0]    eb_cmd [$];
    logic [AW-1:0] eb_addr [$];
    logic [DW-1:0] eb_data [$];
    string         eb_tag [$];
    logic [DW-1:0] ef_data [$];
    string         ef_tag [$];
    int            er_data [$];
    string         er_tag [$];

    always #5 clk = ~clk;

    assign bus_rdata_i = mem[bus_addr_o];

    msi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) dut_i (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic exp_bus(input logic [1:0] c, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input string tag);
        eb_cmd.push_back(c);
        eb_addr.push_back(a);
        eb_data.push_back(d);
        eb_tag.push_back(tag);
    endtask

    task automatic exp_flush(input logic [DW-1:0] d, input string tag);
        ef_data.push_back(d);
        ef_tag.push_back(tag);
    endtask

    // arbiter: grant shortly after each rising edge
    always @(posedge clk) begin
        #3;
        bus_gnt_i = bus_req_o && gnt_en && (snp_cmd_i == 2'b00);
    end

    // monitor: compares observed events against the scoreboard queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_cmd_o != 2'b00) begin
                if (eb_cmd.size() == 0) begin
                    chk(1'b0, "R9 unexpected bus command", {bus_cmd_o, bus_addr_o}, 0);
                end else begin
                    logic [1:0]    c;
                    logic [AW-1:0] a;
                    logic [DW-1:0] d;
                    string         t;
                    c = eb_cmd.pop_front();
                    a = eb_addr.pop_front();
                    d = eb_data.pop_front();
                    t = eb_tag.pop_front();
                    chk(bus_cmd_o == c && bus_addr_o == a && (c != 2'b11 || bus_data_o == d),
                        t, {bus_cmd_o, bus_addr_o, bus_data_o}, {c, a, d});
                end
                if (bus_cmd_o == 2'b11) mem[bus_addr_o] = bus_data_o;
            end
            if (snp_flush_o) begin
                if (ef_data.size() == 0) begin
                    chk(1'b0, "R6 unexpected flush", snp_flush_data_o, 0);
                end else begin
                    logic [DW-1:0] d;
                    string         t;
                    d = ef_data.pop_front();
                    t = ef_tag.pop_front();
                    chk(snp_flush_data_o == d, t, snp_flush_data_o, d);
                end
                mem[last_snp] = snp_flush_data_o;
            end
            if (cpu_done_o) begin
                if (er_data.size() == 0) begin
                    chk(1'b0, "R11 unexpected done", 1, 0);
                end else begin
                    int    e;
                    string t;
                    e = er_data.pop_front();
                    t = er_tag.pop_front();
                    if (e >= 0) chk(cpu_rdata_o == e[DW-1:0], t, cpu_rdata_o, e);
                end
            end
        end
    end

    task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int exp_rd, input int exp_lat, input string tag);
        int cnt;
        er_data.push_back(we ? -1 : exp_rd);
        er_tag.push_back(tag);
        @(posedge clk);
        #1;
        cpu_req_i   = 1'b1;
        cpu_we_i    = we;
        cpu_addr_i  = a;
        cpu_wdata_i = d;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!cpu_done_o && cnt < 5000);
        cpu_req_i = 1'b0;
        if (exp_lat > 0) chk(cnt == exp_lat, {tag, " latency"}, cnt, exp_lat);
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a);
        @(posedge clk);
        #1;
        snp_cmd_i  = c;
        snp_addr_i = a;
        last_snp   = a;
        @(posedge clk);
        #1;
        snp_cmd_i = 2'b00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = DW'(i) ^ 8'h5A;
        rst_n = 1'b0;
        idle(3);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_done_o && !bus_req_o && bus_cmd_o == 2'b00 && !snp_flush_o,
            "R1 reset outputs", {cpu_done_o, bus_req_o, bus_cmd_o, snp_flush_o}, 0);

        // R1 R2: first read misses on an Invalid line
        exp_bus(2'b01, 8'h10, 8'h00, "R2 read miss command");
        cpu_op(1'b0, 8'h10, 8'h00, 8'h4A, -1, "R2 read miss fill");
        cpu_op(1'b0, 8'h10, 8'h00, 8'h4A, 2, "R4 read hit Shared");

        // R3: write to Shared line of same tag is an upgrade miss
        exp_bus(2'b10, 8'h10, 8'h00, "R3 write miss on Shared");
        cpu_op(1'b1, 8'h10, 8'hA1, -1, -1, "R3 write upgrade");
        cpu_op(1'b1, 8'h10, 8'hB2, -1, 2, "R4 write hit Exclusive");
        cpu_op(1'b0, 8'h10, 8'h00, 8'hB2, 2, "R4 read hit Exclusive");

        // R5: conflict with dirty line writes back first
        exp_bus(2'b11, 8'h10, 8'hB2, "R5 victim write-back");
        exp_bus(2'b01, 8'h20, 8'h00, "R5 miss after write-back");
        cpu_op(1'b0, 8'h20, 8'h00, 8'h7A, -1, "R5 read after eviction");

        // R3: write to Invalid line
        exp_bus(2'b10, 8'h05, 8'h00, "R3 write miss on Invalid");
        cpu_op(1'b1, 8'h05, 8'h33, -1, -1, "R3 write Invalid");

        // R7: remote read miss demotes Exclusive to Shared with flush
        exp_flush(8'h33, "R7 flush on remote read");
        snoop(2'b01, 8'h05);
        idle(2);
        cpu_op(1'b0, 8'h05, 8'h00, 8'h33, 2, "R7 line Shared keeps data");
        exp_bus(2'b10, 8'h05, 8'h00, "R7 write needs miss after demotion");
        cpu_op(1'b1, 8'h05, 8'h44, -1, -1, "R7 write after demotion");

        // R8: remote write miss invalidates Exclusive with flush
        exp_flush(8'h44, "R8 flush on remote write");
        snoop(2'b10, 8'h05);
        idle(2);
        exp_bus(2'b01, 8'h05, 8'h00, "R8 line Invalid after remote write");
        cpu_op(1'b0, 8'h05, 8'h00, 8'h44, -1, "R8 refetch flushed data");

        // R6: remote write miss invalidates Shared without flush
        snoop(2'b10, 8'h05);
        idle(2);
        exp_bus(2'b01, 8'h05, 8'h00, "R6 Shared invalidated");
        cpu_op(1'b0, 8'h05, 8'h00, 8'h44, -1, "R6 refetch");

        // R10: non-matching tag and write-back snoops are ignored
        snoop(2'b10, 8'h09);
        idle(2);
        cpu_op(1'b0, 8'h05, 8'h00, 8'h44, 2, "R10 other tag ignored");
        snoop(2'b11, 8'h05);
        idle(2);
        cpu_op(1'b0, 8'h05, 8'h00, 8'h44, 2, "R10 write-back snoop ignored");

        // R10: snoop in the same cycle delays acceptance by one cycle
        fork
            cpu_op(1'b0, 8'h05, 8'h00, 8'h44, 3, "R10 snoop priority");
            snoop(2'b01, 8'h0A);
        join

        // R9: no update before grant; snoop to pending block restarts
        gnt_en = 1'b0;
        exp_bus(2'b10, 8'h05, 8'h00, "R9 write miss after restart");
        fork
            cpu_op(1'b1, 8'h05, 8'h77, -1, -1, "R9 pending write");
        join_none
        idle(3);
        @(negedge clk);
        chk(bus_req_o == 1'b1, "R11 request held while waiting", bus_req_o, 1);
        snoop(2'b01, 8'h05);
        idle(2);
        gnt_en = 1'b1;
        wait fork;
        exp_flush(8'h77, "R9 written data present after grant");
        snoop(2'b01, 8'h05);
        idle(2);

        // R9: snoop takes the dirty victim while write-back is pending
        exp_bus(2'b10, 8'h20, 8'h00, "R3 upgrade before victim test");
        cpu_op(1'b1, 8'h20, 8'h88, -1, -1, "R3 make victim dirty");
        gnt_en = 1'b0;
        fork
            cpu_op(1'b0, 8'h30, 8'h00, 8'h6A, -1, "R9 read after restart");
        join_none
        idle(3);
        @(negedge clk);
        chk(bus_req_o == 1'b1, "R5 request for write-back", bus_req_o, 1);
        exp_flush(8'h88, "R9 snoop flushes pending victim");
        snoop(2'b01, 8'h20);
        exp_bus(2'b01, 8'h30, 8'h00, "R9 no write-back after restart");
        idle(2);
        gnt_en = 1'b1;
        wait fork;

        idle(4);
        @(negedge clk);
        chk(eb_cmd.size() == 0, "R5 missing bus commands", eb_cmd.size(), 0);
        chk(ef_data.size() == 0, "R7 missing flushes", ef_data.size(), 0);
        chk(er_data.size() == 0, "R11 missing responses", er_data.size(), 0);
        finish_run();
    end
endmodule